// File: doc/BRIEF.md
# Ternary Table Maintenance Controller

This block maintains a small ternary lookup table whose entries are stored as bit pairs. Software or a control engine hands it a 32-bit value word and a 32-bit care word, where a care bit of 0 marks a don't-care position. The block converts the two words into the paired storage form and writes the result at a chosen index. Every entry has a validity bit. A write sets that bit. A delete clears it, and a delete can name the entry directly or locate it by ternary matching of a key against the live entries.

Each write or delete puts the index it touched on a side output together with a one-cycle strobe. An external associated-data RAM can use that output to update the same index in the same step. An associative delete that finds no live matching entry raises a one-cycle miss flag and leaves the table as it was. A read-by-index operation returns the stored pair and its validity bit, so the table contents can be observed.

Operations are accepted one per cycle. Each result appears on registered outputs in the cycle after the operation is presented.

Top module: `tt_maint`

## Requirements
- R1: A write with value A and care word M stores a 64-bit entry whose bits 31..0 are A&M and whose bits 63..32 are ~A&M. A read returns this entry as {high half, low half}.
- R2: A write (op_code 0) sets the validity bit of the target index.
- R3: A write publishes its index on aout_idx with aout_vld high for exactly one cycle, in the cycle after the operation.
- R4: An index delete (op_code 1) clears the validity bit of the given index and publishes that index with the aout_vld strobe. This happens even when the entry was already invalid.
- R5: An associative delete (op_code 2) uses op_val as its key. A key bit of 1 matches a stored pair of (low=1, high=0) or (0,0). A key bit of 0 matches (0,1) or (0,0). Only valid entries can match. The delete clears only the lowest-index matching entry and publishes that index.
- R6: An associative delete with no valid matching entry changes no validity bit, leaves aout_vld low, and pulses miss for one cycle.
- R7: A write to an index that is already valid replaces the stored pair and still publishes the index.
- R8: A synchronous reset clears every validity bit and all strobes. Entries written before the reset read back as invalid and no longer match associative deletes.
- R9: A read (op_code 3) returns the stored pair on rd_data and the validity bit on rd_entry_valid, with rd_vld high, in the cycle after the operation. It changes no validity bit and raises neither aout_vld nor miss.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| op_valid | input | 1 | Operation present this cycle |
| op_code | input | 2 | 0 write, 1 index delete, 2 associative delete, 3 read |
| op_idx | input | IDX_W (4) | Target index for write, index delete and read |
| op_val | input | HALF_W (32) | Value word for write; key for associative delete |
| op_care | input | HALF_W (32) | Care word for write (0 = don't care) |
| aout_vld | output | 1 | One-cycle strobe marking a published index |
| aout_idx | output | IDX_W (4) | Index touched by the last write or delete |
| miss | output | 1 | One-cycle flag: associative delete found nothing |
| rd_vld | output | 1 | One-cycle strobe marking read data |
| rd_data | output | 2*HALF_W (64) | Stored pair of the read entry |
| rd_entry_valid | output | 1 | Validity bit of the read entry |

## Verification
On every cycle, the assertions check the following. Writes set validity and publish their own index. Index deletes clear validity and publish. Overwrites still publish. An associative hit always points at a live entry. A miss or a read never raises the strobe and never disturbs any validity bit. Reset clears all validity.

The stored bit encoding can only be shown through bench scenarios that write and read back. So can the ternary compare rule with its don't-care positions, the choice of the lowest matching index among several live candidates, and the loss of entries across a reset.

// File: rtl/tt_pkg.sv
package tt_pkg;
    typedef enum logic [1:0] {
        OP_WR      = 2'd0,
        OP_DEL_IDX = 2'd1,
        OP_DEL_KEY = 2'd2,
        OP_RD      = 2'd3
    } tt_op_e;
endpackage

// File: rtl/tt_pair_enc.sv
module tt_pair_enc #(
    parameter int HALF_W = 32,
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic [HALF_W-1:0] val,
    input  logic [HALF_W-1:0] care,
    output logic [WORD_W-1:0] pair
);
    // high half flags positions holding 0, low half flags positions holding 1
    always_comb begin
        pair = {(~val) & care, val & care};
    end
endmodule

// File: rtl/tt_store.sv
module tt_store #(
    parameter int DEPTH  = 16,
    parameter int WORD_W = 64,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                          clk,
    input  logic                          we,
    input  logic [IDX_W-1:0]              widx,
    input  logic [WORD_W-1:0]             wdata,
    output logic [DEPTH-1:0][WORD_W-1:0]  rows
);
    // data rows carry no reset; validity lives in the controller
    for (genvar g = 0; g < DEPTH; g++) begin : g_row
        logic [WORD_W-1:0] row_q;
        always_ff @(posedge clk) begin
            if (we && (widx == IDX_W'(g))) begin
                row_q <= wdata;
            end
        end
        assign rows[g] = row_q;
    end
endmodule

// File: rtl/tt_match_pe.sv
module tt_match_pe #(
    parameter int DEPTH  = 16,
    parameter int HALF_W = 32,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic [HALF_W-1:0]             key,
    input  logic [DEPTH-1:0][WORD_W-1:0]  rows,
    input  logic [DEPTH-1:0]              live,
    output logic                          hit,
    output logic [IDX_W-1:0]              hit_idx
);
    logic [DEPTH-1:0] hitv;

    for (genvar g = 0; g < DEPTH; g++) begin : g_cmp
        logic [HALF_W-1:0] lo, hi, clash;
        assign lo    = rows[g][HALF_W-1:0];
        assign hi    = rows[g][WORD_W-1:HALF_W];
        assign clash = (key & hi) | ((~key) & lo);
        assign hitv[g] = live[g] & ~(|clash);
    end

    // lowest index wins
    always_comb begin
        hit     = 1'b0;
        hit_idx = '0;
        for (int i = DEPTH - 1; i >= 0; i--) begin
            if (hitv[i]) begin
                hit     = 1'b1;
                hit_idx = IDX_W'(i);
            end
        end
    end
endmodule

// File: rtl/tt_maint.sv
module tt_maint #(
    parameter int DEPTH  = 16,
    parameter int HALF_W = 32,
    localparam int IDX_W  = $clog2(DEPTH),
    localparam int WORD_W = 2 * HALF_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              op_valid,
    input  logic [1:0]        op_code,
    input  logic [IDX_W-1:0]  op_idx,
    input  logic [HALF_W-1:0] op_val,
    input  logic [HALF_W-1:0] op_care,
    output logic              aout_vld,
    output logic [IDX_W-1:0]  aout_idx,
    output logic              miss,
    output logic              rd_vld,
    output logic [WORD_W-1:0] rd_data,
    output logic              rd_entry_valid
);
    import tt_pkg::*;

    typedef struct packed {
        logic [DEPTH-1:0]  vld;
        logic              aout_v;
        logic [IDX_W-1:0]  aout_i;
        logic              miss;
        logic              rd_v;
        logic [WORD_W-1:0] rd_d;
        logic              rd_ev;
    } state_t;

    state_t s_d, s_q;

    logic                         we_d;
    logic [WORD_W-1:0]            pair_w;
    logic [DEPTH-1:0][WORD_W-1:0] rows_w;
    logic                         m_hit;
    logic [IDX_W-1:0]             m_idx;
    tt_op_e                       op_e;

    assign op_e = tt_op_e'(op_code);

    tt_pair_enc #(.HALF_W(HALF_W)) u_enc (
        .val  (op_val),
        .care (op_care),
        .pair (pair_w)
    );

    tt_store #(.DEPTH(DEPTH), .WORD_W(WORD_W)) u_store (
        .clk   (clk),
        .we    (we_d),
        .widx  (op_idx),
        .wdata (pair_w),
        .rows  (rows_w)
    );

    tt_match_pe #(.DEPTH(DEPTH), .HALF_W(HALF_W)) u_match (
        .key     (op_val),
        .rows    (rows_w),
        .live    (s_q.vld),
        .hit     (m_hit),
        .hit_idx (m_idx)
    );

    always_comb begin
        s_d        = s_q;
        s_d.aout_v = 1'b0;
        s_d.miss   = 1'b0;
        s_d.rd_v   = 1'b0;
        we_d       = 1'b0;
        if (op_valid) begin
            case (op_e)
                OP_WR: begin
                    we_d               = 1'b1;
                    s_d.vld[op_idx]    = 1'b1;
                    s_d.aout_v         = 1'b1;
                    s_d.aout_i         = op_idx;
                end
                OP_DEL_IDX: begin
                    s_d.vld[op_idx]    = 1'b0;
                    s_d.aout_v         = 1'b1;
                    s_d.aout_i         = op_idx;
                end
                OP_DEL_KEY: begin
                    if (m_hit) begin
                        s_d.vld[m_idx] = 1'b0;
                        s_d.aout_v     = 1'b1;
                        s_d.aout_i     = m_idx;
                    end else begin
                        s_d.miss       = 1'b1;
                    end
                end
                OP_RD: begin
                    s_d.rd_v           = 1'b1;
                    s_d.rd_d           = rows_w[op_idx];
                    s_d.rd_ev          = s_q.vld[op_idx];
                end
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            s_q <= '0;
        end else begin
            s_q <= s_d;
        end
    end

    assign aout_vld       = s_q.aout_v;
    assign aout_idx       = s_q.aout_i;
    assign miss           = s_q.miss;
    assign rd_vld         = s_q.rd_v;
    assign rd_data        = s_q.rd_d;
    assign rd_entry_valid = s_q.rd_ev;

    AST_WR_SETS_VALID: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 2'd0) |=> s_q.vld[$past(op_idx)]); // R2

    AST_WR_PUBLISH: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 2'd0) |=> (aout_vld && aout_idx == $past(op_idx))); // R3

    AST_DEL_IDX_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 2'd1) |=>
        (!s_q.vld[$past(op_idx)] && aout_vld && aout_idx == $past(op_idx))); // R4

    AST_KEY_HIT_LIVE: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 2'd2 && m_hit) |-> s_q.vld[m_idx]); // R5

    AST_MISS_QUIET: assert property (@(posedge clk) disable iff (rst)
        miss |-> (!aout_vld && $stable(s_q.vld))); // R6

    AST_OVERWRITE_PUB: assert property (@(posedge clk) disable iff (rst)
        (op_valid && op_code == 2'd0 && s_q.vld[op_idx]) |=>
        (aout_vld && aout_idx == $past(op_idx))); // R7

    AST_RST_CLEARS: assert property (@(posedge clk)
        rst |=> (s_q.vld == '0 && !aout_vld && !miss)); // R8

    AST_RD_QUIET: assert property (@(posedge clk) disable iff (rst)
        rd_vld |-> (!aout_vld && !miss && $stable(s_q.vld))); // R9
endmodule

// File: tb/sim_tt_maint.sv
module sim_tt_maint;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        op_valid = 1'b0;
    logic [1:0]  op_code = 2'd0;
    logic [3:0]  op_idx = 4'd0;
    logic [31:0] op_val = 32'd0;
    logic [31:0] op_care = 32'd0;
    logic        aout_vld;
    logic [3:0]  aout_idx;
    logic        miss;
    logic        rd_vld;
    logic [63:0] rd_data;
    logic        rd_entry_valid;

    int checks = 0;
    int errors = 0;

    always #4 clk = ~clk; // 125 MHz

    tt_maint u0 (
        .clk(clk), .rst(rst), .op_valid(op_valid), .op_code(op_code),
        .op_idx(op_idx), .op_val(op_val), .op_care(op_care),
        .aout_vld(aout_vld), .aout_idx(aout_idx), .miss(miss),
        .rd_vld(rd_vld), .rd_data(rd_data), .rd_entry_valid(rd_entry_valid)
    );

    typedef struct packed {
        logic [1:0]  op;
        logic [3:0]  idx;
        logic [31:0] a;
        logic [31:0] m;
        logic        ev;
        logic [3:0]  eidx;
        logic        emiss;
        logic        erv;
        logic [63:0] erd;
        logic        erdv;
    } vec_t;

    localparam int NV = 18;
    localparam vec_t VECS [NV] = '{
        // R3 write /16 prefix at 3
        '{2'd0, 4'd3,  32'hC0A80000, 32'hFFFF0000, 1'b1, 4'd3,  1'b0, 1'b0, 64'h0, 1'b0},
        // R1 R2 read back encoding
        '{2'd3, 4'd3,  32'h0, 32'h0, 1'b0, 4'd0, 1'b0, 1'b1, 64'h3F570000_C0A80000, 1'b1},
        '{2'd0, 4'd1,  32'hC0A80100, 32'hFFFFFF00, 1'b1, 4'd1,  1'b0, 1'b0, 64'h0, 1'b0},
        '{2'd0, 4'd5,  32'h00000000, 32'h00000000, 1'b1, 4'd5,  1'b0, 1'b0, 64'h0, 1'b0},
        // R5 three candidates, lowest wins
        '{2'd2, 4'd0,  32'hC0A80105, 32'h0, 1'b1, 4'd1,  1'b0, 1'b0, 64'h0, 1'b0},
        '{2'd2, 4'd0,  32'hC0A80105, 32'h0, 1'b1, 4'd3,  1'b0, 1'b0, 64'h0, 1'b0},
        '{2'd3, 4'd1,  32'h0, 32'h0, 1'b0, 4'd0, 1'b0, 1'b1, 64'h3F57FE00_C0A80100, 1'b0},
        '{2'd2, 4'd0,  32'h0A000001, 32'h0, 1'b1, 4'd5,  1'b0, 1'b0, 64'h0, 1'b0},
        // R6 nothing live matches
        '{2'd2, 4'd0,  32'h0A000001, 32'h0, 1'b0, 4'd0,  1'b1, 1'b0, 64'h0, 1'b0},
        '{2'd0, 4'd15, 32'h12345678, 32'hFFFFFFFF, 1'b1, 4'd15, 1'b0, 1'b0, 64'h0, 1'b0},
        // R7 overwrite valid entry
        '{2'd0, 4'd15, 32'hAAAA5555, 32'h0F0F0F0F, 1'b1, 4'd15, 1'b0, 1'b0, 64'h0, 1'b0},
        '{2'd3, 4'd15, 32'h0, 32'h0, 1'b0, 4'd0, 1'b0, 1'b1, 64'h05050A0A_0A0A0505, 1'b1},
        // R6 old data no longer matches
        '{2'd2, 4'd0,  32'h12345678, 32'h0, 1'b0, 4'd0,  1'b1, 1'b0, 64'h0, 1'b0},
        '{2'd2, 4'd0,  32'h0A0A0505, 32'h0, 1'b1, 4'd15, 1'b0, 1'b0, 64'h0, 1'b0},
        // R4 delete of never-valid index still publishes
        '{2'd1, 4'd0,  32'h0, 32'h0, 1'b1, 4'd0,  1'b0, 1'b0, 64'h0, 1'b0},
        '{2'd0, 4'd2,  32'hFFFFFFFF, 32'hFFFFFFFF, 1'b1, 4'd2, 1'b0, 1'b0, 64'h0, 1'b0},
        '{2'd1, 4'd2,  32'h0, 32'h0, 1'b1, 4'd2,  1'b0, 1'b0, 64'h0, 1'b0},
        '{2'd3, 4'd2,  32'h0, 32'h0, 1'b0, 4'd0, 1'b0, 1'b1, 64'h00000000_FFFFFFFF, 1'b0}
    };

    task automatic chk(input string tag, input logic [63:0] act, input logic [63:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    function automatic string tag_of(input logic [1:0] op);
        case (op)
            2'd0:    return "R3/R7";
            2'd1:    return "R4";
            2'd2:    return "R5/R6";
            default: return "R1/R2/R9";
        endcase
    endfunction

    // drive at a falling edge, result registered at the next rising edge
    task automatic run_op(input logic [1:0] op, input logic [3:0] idx,
                          input logic [31:0] a, input logic [31:0] m);
        @(negedge clk);
        op_valid = 1'b1; op_code = op; op_idx = idx; op_val = a; op_care = m;
        @(negedge clk);
        op_valid = 1'b0;
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        // R8 reset state
        chk("R8 aout_vld after reset", 64'(aout_vld), 64'd0);
        chk("R8 miss after reset", 64'(miss), 64'd0);
        chk("R8 rd_vld after reset", 64'(rd_vld), 64'd0);

        for (int i = 0; i < NV; i++) begin
            run_op(VECS[i].op, VECS[i].idx, VECS[i].a, VECS[i].m);
            chk({tag_of(VECS[i].op), " aout_vld"}, 64'(aout_vld), 64'(VECS[i].ev));
            if (VECS[i].ev) chk({tag_of(VECS[i].op), " aout_idx"}, 64'(aout_idx), 64'(VECS[i].eidx));
            chk({tag_of(VECS[i].op), " miss"}, 64'(miss), 64'(VECS[i].emiss));
            chk({tag_of(VECS[i].op), " rd_vld"}, 64'(rd_vld), 64'(VECS[i].erv));
            if (VECS[i].erv) begin
                chk("R1 rd_data", rd_data, VECS[i].erd);
                chk("R2/R9 rd_entry_valid", 64'(rd_entry_valid), 64'(VECS[i].erdv));
            end
        end

        // R3 strobe lasts one cycle
        run_op(2'd0, 4'd4, 32'h0, 32'h0);
        chk("R3 strobe on", 64'(aout_vld), 64'd1);
        @(negedge clk);
        chk("R3 strobe one cycle", 64'(aout_vld), 64'd0);

        // R8 reset drops validity
        rst = 1'b1;
        repeat (2) @(negedge clk);
        rst = 1'b0;
        chk("R8 aout_vld in reset", 64'(aout_vld), 64'd0);
        run_op(2'd3, 4'd4, 32'h0, 32'h0);
        chk("R8 entry invalid after reset", 64'(rd_entry_valid), 64'd0);
        run_op(2'd2, 4'd0, 32'h5A5A5A5A, 32'h0);
        chk("R8 no match after reset", 64'(miss), 64'd1);
        chk("R8 no publish after reset", 64'(aout_vld), 64'd0);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        errors++;
        $display("FAIL watchdog actual=running expected=done");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule